// File: doc/BRIEF.md
# Registered Memory-Window Decoder

This block maps a 16-bit bus address onto eight uneven address windows at the top of the address space. The address arrives as a high byte and a low byte. When the address strobe is high at a rising clock edge, the block registers a one-hot chip-select for the matching window. If no window matches, it registers a bus-error flag instead. All nine outputs come straight from flops, so downstream devices see glitch-free selects one clock after the address is sampled.

The windows, from the narrowest to the widest, are: the single address E2AB, then E2AC–E2AF, E2B0–E2BF, E2C0–E2FF, E300–E3FF, E400–E7FF, E800–EFFF and F000–FFFF. Every address below E2AB is unmapped. When the strobe is low, the selects drop to zero at the next edge and the error flag keeps its last value.

Top module: `mem_window_decoder`

## Requirements
- R1: An active-high synchronous reset clears all eight selects and the error flag to zero at the next rising edge.
- R2: With the strobe high, address E2AB alone sets sel[7] at the next edge.
- R3: With the strobe high, E2AC–E2AF set sel[6] and E2B0–E2BF set sel[5].
- R4: With the strobe high, E2C0–E2FF set sel[4] and E300–E3FF set sel[3].
- R5: With the strobe high, E400–E7FF set sel[2], E800–EFFF set sel[1] and F000–FFFF set sel[0].
- R6: A strobed address below E2AB leaves all selects at zero and sets the error flag.
- R7: A strobed address that falls in any window clears the error flag.
- R8: With the strobe low, all selects are zero after the next edge and the error flag holds its previous value.
- R9: At most one select is high at a time, and no select is high together with the error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 1 | Address valid strobe |
| addr_hi | input | 8 | Address bits 15:8 |
| addr_lo | input | 8 | Address bits 7:0 |
| sel | output | 8 | Registered one-hot window selects (bit 7 = E2AB) |
| bus_err | output | 1 | Registered unmapped-address flag |

## Verification
Some properties are checked on every clock by the assertions: the selects stay one-hot-or-zero and never overlap the error flag, the reset result holds, the selects clear after a strobe-low cycle, and the error flag holds while the strobe is low. Only the bench scenarios can show that the window edges sit at the right addresses. To do that they drive each window's lower bound, upper bound and an interior point, the addresses just below E2AB, and sequences that check the error flag is kept and then cleared.

// File: rtl/mem_window_decoder.sv
module mem_window_decoder #(
  parameter int AW = 16,
  parameter int NSEL = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            strobe,
  input  logic [AW/2-1:0] addr_hi,
  input  logic [AW/2-1:0] addr_lo,
  output logic [NSEL-1:0] sel,
  output logic            bus_err
);
  localparam logic [AW-1:0] LOW_EDGE [NSEL] = '{
    16'hF000, 16'hE800, 16'hE400, 16'hE300,
    16'hE2C0, 16'hE2B0, 16'hE2AC, 16'hE2AB
  };

  logic [AW-1:0]   addr;
  logic [NSEL-1:0] hit;
  logic [NSEL-1:0] match;

  assign addr = {addr_hi, addr_lo};

  for (genvar i = 0; i < NSEL; i++) begin : g_cmp
    assign hit[i] = addr >= LOW_EDGE[i];
  end

  for (genvar i = 0; i < NSEL; i++) begin : g_win
    if (i == 0) begin : g_top
      assign match[i] = hit[i];
    end else begin : g_mid
      assign match[i] = hit[i] & ~hit[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel     <= '0;
      bus_err <= 1'b0;
    end else if (strobe) begin
      sel     <= match;
      bus_err <= ~|match;
    end else begin
      sel     <= '0;
    end
  end
endmodule

// File: rtl/mem_window_decoder_chk.sv
module mem_window_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic       strobe,
  input logic [7:0] sel,
  input logic       bus_err
);
  logic seen;
  always_ff @(posedge clk) seen <= 1'b1;

  AST_RESET_CLEAR: assert property (@(posedge clk) seen && rst |=> (sel == '0 && !bus_err)); // R1
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst || !seen) $onehot0(sel)); // R9
  AST_SEL_ERR_EXCL: assert property (@(posedge clk) disable iff (rst || !seen) !(bus_err && sel != '0)); // R9
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst || !seen) !strobe |=> sel == '0); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst || !seen) !strobe |=> $stable(bus_err)); // R8
  AST_STROBE_RESULT: assert property (@(posedge clk) disable iff (rst || !seen) strobe |=> $onehot(sel) != bus_err); // R6
endmodule

bind mem_window_decoder mem_window_decoder_chk u_chk (
  .clk(clk), .rst(rst), .strobe(strobe), .sel(sel), .bus_err(bus_err)
);

// File: tb/mem_window_decoder_test.sv
`timescale 1ns/1ps
module mem_window_decoder_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strobe = 1'b0;
  logic [7:0] addr_hi = '0, addr_lo = '0;
  logic [7:0] sel;
  logic       bus_err;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  mem_window_decoder uut (
    .clk(clk), .rst(rst), .strobe(strobe),
    .addr_hi(addr_hi), .addr_lo(addr_lo), .sel(sel), .bus_err(bus_err)
  );

  task automatic step(input logic r, input logic s, input logic [15:0] a);
    @(negedge clk);
    rst = r; strobe = s; {addr_hi, addr_lo} = a;
    @(posedge clk); #1;
  endtask

  task automatic expect_out(input string req, input logic [8:0] exp);
    checks++;
    if ({bus_err, sel} !== exp) begin
      fails++;
      $display("FAIL %s: actual err,sel=%h expected %h", req, {bus_err, sel}, exp);
    end
  endtask

  task automatic probe(input string req, input logic [15:0] a, input logic [8:0] exp);
    step(1'b0, 1'b1, a);
    expect_out(req, exp);
  endtask

  task automatic test_reset();
    step(1'b1, 1'b1, 16'hFFFF);
    expect_out("R1 reset", 9'h000);
  endtask

  task automatic test_windows();
    probe("R2", 16'hE2AB, 9'h080);
    probe("R3", 16'hE2AC, 9'h040); probe("R3", 16'hE2AE, 9'h040); probe("R3", 16'hE2AF, 9'h040);
    probe("R3", 16'hE2B0, 9'h020); probe("R3", 16'hE2B7, 9'h020); probe("R3", 16'hE2BF, 9'h020);
    probe("R4", 16'hE2C0, 9'h010); probe("R4", 16'hE2D2, 9'h010); probe("R4", 16'hE2FF, 9'h010);
    probe("R4", 16'hE300, 9'h008); probe("R4", 16'hE3F0, 9'h008); probe("R4", 16'hE3FF, 9'h008);
    probe("R5", 16'hE400, 9'h004); probe("R5", 16'hE7F3, 9'h004); probe("R5", 16'hE7FF, 9'h004);
    probe("R5", 16'hE800, 9'h002); probe("R5", 16'hEAAA, 9'h002); probe("R5", 16'hEFFF, 9'h002);
    probe("R5", 16'hF000, 9'h001); probe("R5", 16'hFABC, 9'h001); probe("R5", 16'hFFFF, 9'h001);
  endtask

  task automatic test_unmapped();
    probe("R6", 16'h0000, 9'h100);
    probe("R6", 16'h00A0, 9'h100);
    probe("R6", 16'hE2AA, 9'h100);
    probe("R7", 16'hE2AB, 9'h080);
    probe("R6", 16'h7FFF, 9'h100);
    probe("R7", 16'hF000, 9'h001);
  endtask

  task automatic test_idle();
    probe("R6", 16'h0002, 9'h100);
    step(1'b0, 1'b0, 16'hFFFF);
    expect_out("R8 hold err", 9'h100);
    step(1'b0, 1'b0, 16'hE2AB);
    expect_out("R8 hold err", 9'h100);
    probe("R7", 16'hE400, 9'h004);
    step(1'b0, 1'b0, 16'h0000);
    expect_out("R8 clear sel", 9'h000);
  endtask

  task automatic test_mid_reset();
    probe("R6", 16'h1234, 9'h100);
    step(1'b1, 1'b1, 16'hFFFF);
    expect_out("R1 mid reset", 9'h000);
    step(1'b0, 1'b0, 16'h0000);
    expect_out("R8 after reset", 9'h000);
  endtask

  initial begin
    #20000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    test_reset();
    test_windows();
    test_unmapped();
    test_idle();
    test_mid_reset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule